// File: doc/BRIEF.md
# Mode-Gated Host Register Front End

This block sits between a host bus and the register file of a display controller. The host reaches it over two address spaces that share one request/acknowledge port: a legacy I/O-port space and a memory-mapped space, selected per request by `req_mm`. A mode bit chooses between legacy planar operation and enhanced linear operation. The mode decides which space a register answers on, and how it answers. The legacy index/data register pairs answer on the I/O space in every mode. The input status word answers on the I/O space only in planar mode. In linear mode it answers only on the memory-mapped space, and a memory-mapped read of it in planar mode is refused with a retry.

The block also holds the interrupt register. The lower half carries latched status bits and the upper half carries enable bits, and `irq_out` is the OR of each status bit masked by its enable. Writing 1 to a status bit clears it, but the bit stays disarmed until a later write of 0 re-arms it. A read of all four bytes of the word clears the status half after returning it. A read of the low two bytes leaves it unchanged.

The controller is a three-state machine. `S_IDLE` waits for `req_valid`. Transition *accept* goes to `S_ACK`, and transition *refuse* goes to `S_RETRY`, which is taken for a memory-mapped read of the status word in planar mode. `S_ACK` drives `ack` and read data for one cycle, then takes transition *complete* back to `S_IDLE`. `S_RETRY` drives `retry` for one cycle, then takes transition *release* back to `S_IDLE`. All write effects and read side effects land at the edge that leaves `S_ACK`.

Top module: `modal_reg_front`

## Requirements
- R1: After reset, `ack`, `retry` and `irq_out` are 0, the mode is planar (mode bit 0), and all enables and status bits are 0 with every interrupt bit armed.
- R2: A request sampled in `S_IDLE` is answered in the next cycle by exactly one of `ack` or `retry`, never both. In the cycle after that, both are 0 again. `rdata` is valid in the `ack` cycle.
- R3: I/O word 2p is the index of pair p and I/O word 2p+1 is its data slot (p = 0..NUM_PAIRS-1). A write with `req_be[0]` loads the index from `wdata[IDX_W-1:0]` or stores `wdata[7:0]` into the slot selected by the index. Reads return the index or the selected slot. These registers work in both modes.
- R4: The input status word returns `{24'b0, sense_in}`. It does so on I/O word 2*NUM_PAIRS in planar mode and on memory word 0 in linear mode. An I/O read of it in linear mode completes with `ack` and returns all zeros.
- R5: A memory read of word 0 in planar mode completes with `retry` instead of `ack`, and has no side effect.
- R6: The mode bit is bit 0 of I/O word 2*NUM_PAIRS+1 and of memory word 2 (1 = linear). A write with `req_be[0]` changes it only at the end of its own response, so the request that carries the write completes under the old mode and the next request sees the new one.
- R7: Writing memory word 1 with the byte lane of status bit i enabled (`req_be[i/8]`) and `wdata[i]`=1 clears status bit i and drops its contribution to `irq_out`.
- R8: After a write-1 clear, bit i reads as 1 and ignores source pulses until a write with `wdata[i]`=0 in its byte lane re-arms it. After re-arming it reads 0, and the next pulse on `irq_src[i]` latches it.
- R9: A read of memory word 1 with `req_be`=4'b1111 returns the status, then clears status bits [15:0]. A read with `req_be`=4'b0011 returns the same view and clears nothing.
- R10: Enable bit i is bit 16+i of memory word 1, written with `req_be[2+i/8]`. `irq_out` is 1 exactly when some latched status bit has its enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request strobe |
| req_mm | input | 1 | Space select: 1 memory-mapped, 0 I/O port |
| req_addr | input | ADDR_W | Word address within the selected space |
| req_be | input | 4 | Byte enables |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data |
| ack | output | 1 | Access completed |
| retry | output | 1 | Access refused, target disconnect |
| rdata | output | 32 | Read data, valid with ack |
| sense_in | input | 8 | Live input status bits |
| irq_src | input | NUM_IRQ | Interrupt source pulses |
| irq_out | output | 1 | Interrupt request |

## Verification
The bench builds the block with NUM_PAIRS=2, PAIR_DEPTH=4, NUM_IRQ=4 and ADDR_W=4. With these values both index/data pairs, the status word and both copies of the mode bit fit in a 4-bit address, and the bench can reach every one of them in both modes. With four interrupt bits, all status bits share byte lane 0 and all enables share lane 2. A single write can therefore clear one bit while re-arming the others, and the difference between the two-byte read and the four-byte read is seen on the same bits.

// File: rtl/modal_reg_pkg.sv
package modal_reg_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ACK   = 2'd1,
        S_RETRY = 2'd2
    } fsm_t;

    typedef enum logic {
        MODE_PLANAR = 1'b0,
        MODE_LINEAR = 1'b1
    } mode_t;

    localparam int MM_STAT_WORD = 0;
    localparam int MM_IRQ_WORD  = 1;
    localparam int MM_MODE_WORD = 2;

endpackage

// File: rtl/idx_bank.sv
module idx_bank #(
    parameter int DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     idx_we,
    input  logic                     dat_we,
    input  logic [7:0]               wbyte,
    output logic [$clog2(DEPTH)-1:0] idx_o,
    output logic [7:0]               dat_o
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [IDX_W-1:0] idx_q;
    logic [7:0]       slot_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (idx_we) begin
            idx_q <= wbyte[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) slot_q[k] <= '0;
        end else if (dat_we) begin
            slot_q[idx_q] <= wbyte;
        end
    end

    assign idx_o = idx_q;
    assign dat_o = slot_q[idx_q];

endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
    parameter int NUM_IRQ = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] src_i,
    input  logic               wr_i,
    input  logic [3:0]         be_i,
    input  logic [31:0]        wdata_i,
    input  logic               rd_full_i,
    output logic [31:0]        view_o,
    output logic               irq_o
);
    logic [NUM_IRQ-1:0] status_q, status_d;
    logic [NUM_IRQ-1:0] armed_q,  armed_d;
    logic [NUM_IRQ-1:0] en_q,     en_d;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
        logic lane_lo, lane_hi, w1c, w0;
        assign lane_lo = be_i[i / 8];
        assign lane_hi = be_i[2 + i / 8];
        assign w1c     = wr_i & lane_lo &  wdata_i[i];
        assign w0      = wr_i & lane_lo & ~wdata_i[i];

        assign status_d[i] = w1c                        ? 1'b0 :
                             (src_i[i] & armed_q[i])    ? 1'b1 :
                             rd_full_i                  ? 1'b0 : status_q[i];
        assign armed_d[i]  = w1c ? 1'b0 : (w0 ? 1'b1 : armed_q[i]);
        assign en_d[i]     = (wr_i & lane_hi) ? wdata_i[16 + i] : en_q[i];

        // R8: a disarmed bit never holds a latched event
        assert_disarmed_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !armed_q[i] |-> !status_q[i]);
    end

    for (genvar j = 0; j < 16; j++) begin : g_view
        if (j < NUM_IRQ) begin : g_live
            assign view_o[j]      = status_q[j] | ~armed_q[j];
            assign view_o[16 + j] = en_q[j];
        end else begin : g_pad
            assign view_o[j]      = 1'b0;
            assign view_o[16 + j] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            armed_q  <= '1;
            en_q     <= '0;
        end else begin
            status_q <= status_d;
            armed_q  <= armed_d;
            en_q     <= en_d;
        end
    end

    assign irq_o = |(status_q & en_q);

    // R9: after a four-byte read only freshly pulsed bits may remain latched
    assert_full_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_full_i && !wr_i) |=> ((status_q & ~$past(src_i)) == '0));

endmodule

// File: rtl/modal_reg_front.sv
module modal_reg_front
    import modal_reg_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int NUM_PAIRS  = 2,
    parameter int PAIR_DEPTH = 4,
    parameter int NUM_IRQ    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_mm,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [3:0]         req_be,
    input  logic               req_write,
    input  logic [31:0]        req_wdata,
    output logic               ack,
    output logic               retry,
    output logic [31:0]        rdata,
    input  logic [7:0]         sense_in,
    input  logic [NUM_IRQ-1:0] irq_src,
    output logic               irq_out
);
    localparam int IDX_W = $clog2(PAIR_DEPTH);
    localparam logic [ADDR_W-1:0] A_IO_STAT = ADDR_W'(2 * NUM_PAIRS);
    localparam logic [ADDR_W-1:0] A_IO_MODE = ADDR_W'(2 * NUM_PAIRS + 1);
    localparam logic [ADDR_W-1:0] A_MM_STAT = ADDR_W'(MM_STAT_WORD);
    localparam logic [ADDR_W-1:0] A_MM_IRQ  = ADDR_W'(MM_IRQ_WORD);
    localparam logic [ADDR_W-1:0] A_MM_MODE = ADDR_W'(MM_MODE_WORD);

    fsm_t              state_q, state_d;
    mode_t             mode_q;
    logic              q_mm, q_write;
    logic [ADDR_W-1:0] q_addr;
    logic [3:0]        q_be;
    logic [31:0]       q_wdata;
    logic              refuse;

    // decode at the request edge: planar-mode memory read of the status word
    assign refuse = req_mm && !req_write && (req_addr == A_MM_STAT) && (mode_q == MODE_PLANAR);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_valid) state_d = refuse ? S_RETRY : S_ACK; // accept / refuse
            S_ACK:   state_d = S_IDLE;                                   // complete
            S_RETRY: state_d = S_IDLE;                                   // release
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_mm <= 1'b0; q_write <= 1'b0; q_addr <= '0; q_be <= '0; q_wdata <= '0;
        end else if (state_q == S_IDLE && req_valid) begin
            q_mm <= req_mm; q_write <= req_write; q_addr <= req_addr;
            q_be <= req_be; q_wdata <= req_wdata;
        end
    end

    logic in_ack, io_acc, mm_acc;
    assign in_ack = (state_q == S_ACK);
    assign io_acc = in_ack && !q_mm;
    assign mm_acc = in_ack &&  q_mm;

    // mode bit: lands at the edge that ends its own response
    logic mode_we;
    assign mode_we = q_write && q_be[0] &&
                     ((io_acc && q_addr == A_IO_MODE) || (mm_acc && q_addr == A_MM_MODE));

    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= MODE_PLANAR;
        else if (mode_we) mode_q <= mode_t'(q_wdata[0]);
    end

    // legacy index/data pairs, I/O space only
    logic [IDX_W-1:0] pair_idx [NUM_PAIRS];
    logic [7:0]       pair_dat [NUM_PAIRS];

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        logic idx_we, dat_we;
        assign idx_we = io_acc && q_write && q_be[0] && (q_addr == ADDR_W'(2 * p));
        assign dat_we = io_acc && q_write && q_be[0] && (q_addr == ADDR_W'(2 * p + 1));
        idx_bank #(.DEPTH(PAIR_DEPTH)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .idx_we (idx_we),
            .dat_we (dat_we),
            .wbyte  (q_wdata[7:0]),
            .idx_o  (pair_idx[p]),
            .dat_o  (pair_dat[p])
        );
    end

    // interrupt register, memory space word 1
    logic        irq_wr, irq_rd_full;
    logic [31:0] irq_view;
    assign irq_wr      = mm_acc &&  q_write && (q_addr == A_MM_IRQ);
    assign irq_rd_full = mm_acc && !q_write && (q_addr == A_MM_IRQ) && (q_be == 4'hF);

    irq_bank #(.NUM_IRQ(NUM_IRQ)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (irq_src),
        .wr_i      (irq_wr),
        .be_i      (q_be),
        .wdata_i   (q_wdata),
        .rd_full_i (irq_rd_full),
        .view_o    (irq_view),
        .irq_o     (irq_out)
    );

    // outputs
    always_comb begin
        ack   = 1'b0;
        retry = 1'b0;
        rdata = '0;
        unique case (state_q)
            S_IDLE: ;
            S_RETRY: retry = 1'b1;
            S_ACK: begin
                ack = 1'b1;
                if (!q_write) begin
                    if (!q_mm) begin
                        for (int p = 0; p < NUM_PAIRS; p++) begin
                            if (q_addr == ADDR_W'(2 * p))     rdata = 32'(pair_idx[p]);
                            if (q_addr == ADDR_W'(2 * p + 1)) rdata = 32'(pair_dat[p]);
                        end
                        if (q_addr == A_IO_STAT && mode_q == MODE_PLANAR) rdata = {24'b0, sense_in};
                        if (q_addr == A_IO_MODE) rdata = {31'b0, mode_q};
                    end else begin
                        if (q_addr == A_MM_STAT) rdata = {24'b0, sense_in};
                        if (q_addr == A_MM_IRQ)  rdata = irq_view;
                        if (q_addr == A_MM_MODE) rdata = {31'b0, mode_q};
                    end
                end
            end
            default: ;
        endcase
    end

    assert_one_response_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack && retry));
    assert_ack_next_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && req_valid) |=> (ack || retry));
    assert_planar_refuse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && req_valid && req_mm && !req_write &&
         req_addr == A_MM_STAT && mode_q == MODE_PLANAR) |=> (retry && !ack));
    assert_mode_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != $past(mode_q)) |-> ($past(state_q) == S_ACK));

endmodule

// File: tb/modal_reg_front_bench.sv
module modal_reg_front_bench;

    typedef struct packed {
        logic [3:0]  src;
        logic        mm;
        logic [3:0]  addr;
        logic [3:0]  be;
        logic        wr;
        logic [31:0] wd;
        logic        exp_retry;
        logic        chk;
        logic [31:0] exp_rd;
        logic        exp_irq;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 30;
    // fields: src, mm, addr, be, wr, wdata, exp_retry, check_rdata, exp_rdata, exp_irq, requirement
    localparam vec_t VECS [NV] = '{
        '{4'h0,1'b0,4'd0,4'h1,1'b1,32'h2,        1'b0,1'b0,32'h0,        1'b0,4'd3},  // R3 pair0 index=2
        '{4'h0,1'b0,4'd1,4'h1,1'b1,32'h3C,       1'b0,1'b0,32'h0,        1'b0,4'd3},  // R3 pair0 slot2
        '{4'h0,1'b0,4'd2,4'h1,1'b1,32'h1,        1'b0,1'b0,32'h0,        1'b0,4'd3},  // R3 pair1 index=1
        '{4'h0,1'b0,4'd3,4'h1,1'b1,32'h5A,       1'b0,1'b0,32'h0,        1'b0,4'd3},  // R3 pair1 slot1
        '{4'h0,1'b0,4'd1,4'h1,1'b0,32'h0,        1'b0,1'b1,32'h3C,       1'b0,4'd3},  // R3
        '{4'h0,1'b0,4'd0,4'h1,1'b0,32'h0,        1'b0,1'b1,32'h2,        1'b0,4'd3},  // R3
        '{4'h0,1'b0,4'd3,4'h1,1'b0,32'h0,        1'b0,1'b1,32'h5A,       1'b0,4'd3},  // R3
        '{4'h0,1'b0,4'd4,4'hF,1'b0,32'h0,        1'b0,1'b1,32'hA5,       1'b0,4'd4},  // R4 planar I/O status
        '{4'h0,1'b1,4'd0,4'hF,1'b0,32'h0,        1'b1,1'b0,32'h0,        1'b0,4'd5},  // R5 refused
        '{4'h0,1'b0,4'd5,4'h1,1'b0,32'h0,        1'b0,1'b1,32'h0,        1'b0,4'd6},  // R6 mode reads planar
        '{4'h0,1'b0,4'd5,4'h1,1'b1,32'h1,        1'b0,1'b0,32'h0,        1'b0,4'd6},  // R6 to linear
        '{4'h0,1'b0,4'd4,4'hF,1'b0,32'h0,        1'b0,1'b1,32'h0,        1'b0,4'd4},  // R4 I/O status zero
        '{4'h0,1'b1,4'd0,4'hF,1'b0,32'h0,        1'b0,1'b1,32'hA5,       1'b0,4'd4},  // R4 memory status
        '{4'h0,1'b0,4'd1,4'h1,1'b0,32'h0,        1'b0,1'b1,32'h3C,       1'b0,4'd3},  // R3 pairs in linear
        '{4'h0,1'b1,4'd2,4'h1,1'b0,32'h0,        1'b0,1'b1,32'h1,        1'b0,4'd6},  // R6 memory copy
        '{4'h0,1'b1,4'd1,4'hC,1'b1,32'h000F0000, 1'b0,1'b0,32'h0,        1'b0,4'd10}, // R10 enable all
        '{4'h1,1'b1,4'd1,4'h3,1'b0,32'h0,        1'b0,1'b1,32'h000F0001, 1'b1,4'd9},  // R9 low read keeps
        '{4'h0,1'b1,4'd1,4'hF,1'b0,32'h0,        1'b0,1'b1,32'h000F0001, 1'b0,4'd9},  // R9 full read clears
        '{4'h0,1'b1,4'd1,4'h3,1'b0,32'h0,        1'b0,1'b1,32'h000F0000, 1'b0,4'd9},  // R9
        '{4'h2,1'b1,4'd1,4'h1,1'b1,32'h2,        1'b0,1'b0,32'h0,        1'b0,4'd7},  // R7 write-1 clear
        '{4'h0,1'b1,4'd1,4'h3,1'b0,32'h0,        1'b0,1'b1,32'h000F0002, 1'b0,4'd8},  // R8 stuck view
        '{4'h2,1'b1,4'd1,4'h3,1'b0,32'h0,        1'b0,1'b1,32'h000F0002, 1'b0,4'd8},  // R8 pulse ignored
        '{4'h0,1'b1,4'd1,4'h1,1'b1,32'h0,        1'b0,1'b0,32'h0,        1'b0,4'd8},  // R8 re-arm
        '{4'h0,1'b1,4'd1,4'h3,1'b0,32'h0,        1'b0,1'b1,32'h000F0000, 1'b0,4'd8},  // R8
        '{4'h2,1'b1,4'd1,4'h3,1'b0,32'h0,        1'b0,1'b1,32'h000F0002, 1'b1,4'd8},  // R8 latches again
        '{4'h0,1'b1,4'd1,4'h4,1'b1,32'h0,        1'b0,1'b0,32'h0,        1'b0,4'd10}, // R10 enables off
        '{4'h0,1'b1,4'd1,4'h3,1'b0,32'h0,        1'b0,1'b1,32'h00000002, 1'b0,4'd10}, // R10
        '{4'h0,1'b1,4'd2,4'h1,1'b1,32'h0,        1'b0,1'b0,32'h0,        1'b0,4'd6},  // R6 back to planar
        '{4'h0,1'b1,4'd0,4'hF,1'b0,32'h0,        1'b1,1'b0,32'h0,        1'b0,4'd5},  // R5
        '{4'h0,1'b0,4'd4,4'hF,1'b0,32'h0,        1'b0,1'b1,32'hA5,       1'b0,4'd4}   // R4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_mm = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [3:0]  req_be = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        ack, retry, irq_out;
    logic [31:0] rdata;
    logic [7:0]  sense_in = 8'hA5;
    logic [3:0]  irq_src = '0;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    modal_reg_front #(.ADDR_W(4), .NUM_PAIRS(2), .PAIR_DEPTH(4), .NUM_IRQ(4)) u_modal_reg_front (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mm(req_mm),
        .req_addr(req_addr), .req_be(req_be), .req_write(req_write), .req_wdata(req_wdata),
        .ack(ack), .retry(retry), .rdata(rdata), .sense_in(sense_in),
        .irq_src(irq_src), .irq_out(irq_out)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int n);
        string tag;
        tag = $sformatf("R%0d vec%0d", v.req, n);
        if (v.src != 4'h0) begin
            @(negedge clk) irq_src = v.src;
            @(negedge clk) irq_src = '0;
        end
        @(negedge clk);
        req_valid = 1'b1; req_mm = v.mm; req_addr = v.addr; req_be = v.be;
        req_write = v.wr; req_wdata = v.wd;
        @(negedge clk);
        req_valid = 1'b0;
        // R2 response one cycle after the request
        check(ack == !v.exp_retry && retry == v.exp_retry, {tag, " R2 response"},
              {30'b0, ack, retry}, {30'b0, !v.exp_retry, v.exp_retry});
        if (v.chk) check(rdata == v.exp_rd, {tag, " rdata"}, rdata, v.exp_rd);
        @(negedge clk);
        check(!ack && !retry, {tag, " R2 idle"}, {30'b0, ack, retry}, 32'h0);
        check(irq_out == v.exp_irq, {tag, " irq_out"}, {31'b0, irq_out}, {31'b0, v.exp_irq});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!ack && !retry && !irq_out, "R1 outputs at reset",
              {29'b0, ack, retry, irq_out}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!ack && !retry && !irq_out, "R1 outputs after reset",
              {29'b0, ack, retry, irq_out}, 32'h0);
        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R1: a second reset restores planar mode and quiet interrupt state
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        run_vec('{4'h0,1'b0,4'd5,4'h1,1'b0,32'h0,1'b0,1'b1,32'h0,1'b0,4'd1}, 100);
        run_vec('{4'h0,1'b1,4'd1,4'h3,1'b0,32'h0,1'b0,1'b1,32'h0,1'b0,4'd1}, 101);
        // R7: clear with its byte lane disabled has no effect
        run_vec('{4'h0,1'b1,4'd1,4'h4,1'b1,32'h00010000,1'b0,1'b0,32'h0,1'b0,4'd10}, 102);
        run_vec('{4'h1,1'b1,4'd1,4'h2,1'b1,32'h1,1'b0,1'b0,32'h0,1'b1,4'd7}, 103);
        run_vec('{4'h0,1'b1,4'd1,4'h1,1'b1,32'h1,1'b0,1'b0,32'h0,1'b0,4'd7}, 104);
        // R6: the write that changes the mode completes under the old one
        run_vec('{4'h0,1'b0,4'd5,4'h1,1'b1,32'h1,1'b0,1'b0,32'h0,1'b0,4'd6}, 105);
        run_vec('{4'h0,1'b1,4'd0,4'hF,1'b0,32'h0,1'b0,1'b1,32'hA5,1'b0,4'd6}, 106);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule